// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of storage stages. On a rising clock edge it either captures a whole parallel word, or moves every stage one place toward the output while the first stage takes a serial input bit. Only the last stage is driven out as the serial output. The block serves both as a parallel-to-serial converter and as a fixed-length serial delay line. A separate bus exposes every stage so the whole register can be observed.

The clock runs freely. A hold input, sampled on the same rising edge, freezes the register without any gating on the clock net. When the active-low clear goes low, every stage goes to zero at once, whatever the other inputs are doing. Release of the clear passes through a short reset synchronizer. Because of this, the register resumes work on a known clock edge.

Top module: `piso_shreg`

## Requirements
- R1: While `clr_n` is low, every stage reads 0 without waiting for a clock edge, whatever `clk_hold`, `shift_sel`, `ser_in` and `par_in` are.
- R2: After `clr_n` rises between two clock edges, the next SYNC_STAGES rising edges leave the register at zero. The first edge that can load or shift is edge SYNC_STAGES+1 (the third edge with the default of 2).
- R3: On a rising edge with `clk_hold` low and `shift_sel` low (load mode), stage i takes `par_in[i]`. Stage 0 is the first stage and stage WIDTH-1 is the last one.
- R4: In load mode the value of `ser_in` has no effect on any stage.
- R5: On a rising edge with `clk_hold` low and `shift_sel` high (shift mode), stage 0 takes `ser_in` and stage i takes the old value of stage i-1.
- R6: On a rising edge with `clk_hold` high, every stage keeps its value, in both load mode and shift mode.
- R7: `ser_out` is the last stage. After a load, `par_in[WIDTH-1]` is seen first, and `par_in[0]` is seen after WIDTH-1 further shifts.
- R8: A bit applied to `ser_in` in shift mode reaches `ser_out` after exactly WIDTH shift edges.
- R9: `dbg_stages[i]` shows stage i for every i. Bit 0 is the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clr_n | input | 1 | Active-low clear: asserts at once, releases through the synchronizer |
| clk_hold | input | 1 | High freezes the register on the current edge |
| shift_sel | input | 1 | 1 = shift, 0 = parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_out | output | 1 | Last stage |
| dbg_stages | output | WIDTH | All stages; bit 0 is the first stage |

## Verification
The bench builds the block with WIDTH=8 and SYNC_STAGES=2. With eight stages, a full load can be followed by seven shifts that bring every loaded bit out in order. A lone serial 1 can also be timed across the whole eight-edge path. With two synchronizer stages, the two dead edges after release can be counted exactly, and a load can be timed on the third edge. Clears are applied in the middle of a stream, with hold high and with a load pending. Hold pulses fall both inside a serial stream and in load mode.

// File: rtl/piso_pkg.sv
`timescale 1ns/100ps
package piso_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } piso_mode_e;
endpackage

// File: rtl/piso_rst_sync.sv
`timescale 1ns/100ps
// Asserts reset at once when arst_n falls; releases it after STAGES edges.
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b0};
  end

  assign rst = sync_q[STAGES-1];
endmodule

// File: rtl/piso_stage_chain.sv
`timescale 1ns/100ps
module piso_stage_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  piso_mode_e       mode,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    logic shift_src;
    logic stage_q;

    if (g == 0) begin : g_head
      assign shift_src = ser_in;
    end else begin : g_body
      assign shift_src = q[g-1];
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst)     stage_q <= 1'b0;
      else if (en) stage_q <= (mode == MODE_SHIFT) ? shift_src : par_in[g];
    end

    assign q[g] = stage_q;
  end
endmodule

// File: rtl/piso_shreg.sv
`timescale 1ns/100ps
module piso_shreg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             clk_hold,
  input  logic             shift_sel,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] dbg_stages
);
  logic             rst_int;
  logic [WIDTH-1:0] chain_q;
  piso_mode_e       mode;

  assign mode = piso_mode_e'(shift_sel);

  piso_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (clr_n),
    .rst    (rst_int)
  );

  piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .rst    (rst_int),
    .en     (~clk_hold),
    .mode   (mode),
    .ser_in (ser_in),
    .par_in (par_in),
    .q      (chain_q)
  );

  assign ser_out    = chain_q[WIDTH-1];
  assign dbg_stages = chain_q;
endmodule

// File: rtl/piso_shreg_chk.sv
`timescale 1ns/100ps
module piso_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             rst,
  input logic             clk_hold,
  input logic             shift_sel,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] dbg_stages
);
  always @(posedge clk) begin
    if (clr_n === 1'b0) begin
      AST_CLEAR_ZERO: assert (dbg_stages == '0); // R1
    end
  end

  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (clr_n !== 1'b1)
    $fell(rst) |-> $past(clr_n)); // R2

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst !== 1'b0)
    (!clk_hold && !shift_sel) |=> (dbg_stages == $past(par_in))); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst !== 1'b0)
    (!clk_hold && shift_sel) |=>
      (dbg_stages == {$past(dbg_stages[WIDTH-2:0]), $past(ser_in)})); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst !== 1'b0)
    clk_hold |=> $stable(dbg_stages)); // R6
endmodule

bind piso_shreg piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .rst        (rst_int),
  .clk_hold   (clk_hold),
  .shift_sel  (shift_sel),
  .ser_in     (ser_in),
  .par_in     (par_in),
  .dbg_stages (dbg_stages)
);

// File: tb/tb_piso_shreg.sv
`timescale 1ns/100ps
module tb_piso_shreg;
  localparam int W    = 8;
  localparam int SYNC = 2;

  typedef struct {
    string      tag;
    logic       ser;
    logic [W-1:0] stg;
  } exp_t;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         clk_hold = 1'b0;
  logic         shift_sel = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;
  logic [W-1:0] dbg_stages;

  int errors = 0;
  int checks = 0;
  int settle = 0;
  logic [W-1:0] mdl = '0;
  exp_t sb[$];

  always #4 clk = ~clk;

  piso_shreg #(.WIDTH(W), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .clr_n(clr_n), .clk_hold(clk_hold), .shift_sel(shift_sel),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out), .dbg_stages(dbg_stages)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one edge's inputs and queue the expected result after it.
  task automatic step(input logic h, input logic s, input logic si,
                      input logic [W-1:0] p, input string tag);
    exp_t e;
    @(negedge clk);
    clk_hold = h; shift_sel = s; ser_in = si; par_in = p;
    if (settle > 0) settle--;
    else if (!h) mdl = s ? {mdl[W-2:0], si} : p;
    e.tag = tag; e.ser = mdl[W-1]; e.stg = mdl;
    sb.push_back(e);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " stages"}, dbg_stages, e.stg);
      chk({e.tag, " ser_out"}, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, e.ser});
    end
  end

  // Clear mid-run, with disturbing inputs, then release between edges.
  task automatic clear_pulse(input string tag);
    @(posedge clk);
    #3;
    clk_hold = 1'b1; shift_sel = 1'b0; par_in = 8'hFF; ser_in = 1'b1;
    clr_n = 1'b0;
    #0.2;
    chk({tag, " clear async"}, dbg_stages, '0);
    chk({tag, " clear ser_out"}, {{(W-1){1'b0}}, ser_out}, '0);
    mdl = '0;
    #0.2;
    clr_n = 1'b1;
    settle = SYNC;
  endtask

  initial begin
    #10;
    chk("R1 reset state", dbg_stages, '0);
    @(posedge clk); #3;
    clr_n = 1'b1; settle = SYNC;
    // R2: two dead edges, then load on the third
    step(0, 0, 1, 8'hFF, "R2 dead edge");
    step(0, 0, 1, 8'hFF, "R2 dead edge");
    step(0, 0, 1, 8'hA5, "R2 third edge load");
    // R3/R4/R9 loads with differing ser_in
    step(0, 0, 0, 8'h3C, "R3 load");
    step(0, 0, 1, 8'h3C, "R4 ser_in ignored");
    step(0, 0, 0, 8'hC3, "R9 stage view");
    // R7: load then W-1 shifts, MSB-first from ser_out
    step(0, 0, 0, 8'hB2, "R7 load");
    for (int i = 0; i < W-1; i++) step(0, 1, 0, 8'h00, "R7 shift out");
    // R8: single 1 travels W edges
    step(0, 1, 1, 8'hFF, "R8 inject");
    for (int i = 0; i < W-1; i++) step(0, 1, 0, 8'hFF, "R8 travel");
    // R5/R6: stream with hold pulses in both modes
    step(0, 1, 1, 8'h00, "R5 shift");
    step(0, 1, 0, 8'h00, "R5 shift");
    step(1, 1, 1, 8'h00, "R6 hold shift");
    step(1, 0, 1, 8'h5A, "R6 hold load");
    step(0, 1, 1, 8'h00, "R5 shift");
    step(1, 1, 0, 8'h00, "R6 hold shift");
    step(0, 1, 1, 8'h00, "R5 shift");
    step(0, 1, 0, 8'h00, "R5 shift");
    wait (sb.size() == 0);
    // R1: clear during a shift stream
    step(0, 1, 1, 8'h00, "R5 shift");
    clear_pulse("R1");
    step(0, 1, 1, 8'hFF, "R2 dead edge");
    step(0, 0, 1, 8'hFF, "R2 dead edge");
    step(0, 0, 0, 8'h69, "R3 load after release");
    step(0, 1, 1, 8'h00, "R5 shift");
    @(negedge clk);
    wait (sb.size() == 0);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule